// File: doc/BRIEF.md
# Inter-Processor Interrupt Channel Controller

This block lets one processing agent exchange doorbell interrupts with eleven peer agents. Software rings a peer by writing a one-hot or multi-bit word to the trigger register. Each selected peer then sees a one-cycle pulse on its own trigger line. In the other direction, each peer raises a request line. That line latches a sticky status bit, which software clears by writing 1 to it. A mask register gates which pending bits drive the single combined interrupt output.

The eleven channels are spread across a 32-bit word at fixed, sparse bit positions, and every register uses the same layout. The mask is never written directly. Software unmasks a channel through an enable register and masks it through a disable register. Both of those are write-only strobes. The status bits are also driven back out to the peers on observation lines, so a sender can tell that its request is still pending. A second set of observation inputs can be read back as a plain level register.

The register port is a simple valid/write/address/data interface. A write takes effect at the clock edge where `busValid` and `busWrite` are both high. Read data is combinational while `busValid` is high and `busWrite` is low, and is zero otherwise.

Top module: `ipi_chan_ctrl`

## Requirements
- R1: Register word offsets are: trigger 0x00, observation 0x04, status 0x10, mask 0x14, enable 0x18, disable 0x1C. Offsets not listed read as zero and writes to them have no effect. Accesses whose two low address bits are nonzero are ignored and read as zero.
- R2: Channel index i (0 to 10) maps to word bit 0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27 in that order. This order ties each bus bit to port bit i of `reqIn`, `obsIn`, `trigOut` and `obsOut`.
- R3: A write to the trigger register raises `trigOut[i]` for exactly one cycle, in the cycle after the write edge, for each channel whose bit was written as 1. All other lines stay low. The trigger register reads as zero.
- R4: When `reqIn[i]` is high at a clock edge, status bit i is set from that edge on and stays set.
- R5: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged. If `reqIn[i]` is high at the same edge as a clear of bit i, the bit stays 1.
- R6: The mask resets to 0x0F0F0301, so all channels start masked. Writes to the mask offset have no effect.
- R7: Writing 1 to an enable bit clears the matching mask bit. Writing 1 to a disable bit sets it. Bits written as 0 leave the mask unchanged. Both the enable and disable registers read as zero.
- R8: `irqOut` is high exactly when some status bit is 1 and its mask bit is 0. It follows the registers in the same cycle.
- R9: The observation register holds the level of `obsIn` sampled at the previous clock edge.
- R10: `obsOut[i]` equals status bit i.
- R11: Reserved bit positions (outside 0x0F0F0301) read as zero in every register and have no effect when written.
- R12: After reset, status, triggers, `obsOut` and `irqOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access request |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 5 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (zero unless a valid read) |
| reqIn | input | 11 | Incoming request level per channel |
| obsIn | input | 11 | Incoming observation level per channel |
| trigOut | output | 11 | One-cycle trigger pulse per channel |
| obsOut | output | 11 | Pending status per channel |
| irqOut | output | 1 | Combined unmasked interrupt |

## Verification
Several rules are checked by the assertions on every cycle:
- a trigger pulse appears only after a trigger write and matches the written channels;
- a request always leaves its status bit set;
- status bits fall only on a clear write;
- the mask changes only on enable or disable writes;
- reserved read bits stay zero.

Other behaviour needs the bench's channel-by-channel sweeps. These cover the exact bit position of every channel, the masked and unmasked interrupt sequence through enable, clear and disable, set winning over a simultaneous clear, observation readback, and the ignored writes to read-only, unmapped and misaligned offsets.

// File: rtl/ipi_chan_pkg.sv
package ipi_chan_pkg;
  localparam int DATA_W = 32;
  localparam int NUM_CH = 11;
  localparam int ADDR_W = 5;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [NUM_CH-1:0] chan_t;

  typedef enum logic [1:0] {RD_ZERO, RD_OBS, RD_STAT, RD_MASK} rdsel_t;

  typedef struct packed {
    logic   trigWr;
    logic   statClr;
    logic   maskEn;
    logic   maskDis;
    rdsel_t rdSel;
  } strobe_t;

  // Word offsets (byte address bits [4:2])
  localparam logic [2:0] OFS_TRIG = 3'd0;
  localparam logic [2:0] OFS_OBS  = 3'd1;
  localparam logic [2:0] OFS_STAT = 3'd4;
  localparam logic [2:0] OFS_MASK = 3'd5;
  localparam logic [2:0] OFS_EN   = 3'd6;
  localparam logic [2:0] OFS_DIS  = 3'd7;

  function automatic int chanBit(input int idx);
    case (idx)
      0:       return 0;
      1:       return 8;
      2:       return 9;
      3, 4, 5, 6:  return 13 + idx;
      default: return 17 + idx;
    endcase
  endfunction

  function automatic chan_t packWord(input word_t w);
    chan_t c;
    for (int i = 0; i < NUM_CH; i++) c[i] = w[chanBit(i)];
    return c;
  endfunction

  function automatic word_t unpackChan(input chan_t c);
    word_t w;
    w = '0;
    for (int i = 0; i < NUM_CH; i++) w[chanBit(i)] = c[i];
    return w;
  endfunction

  localparam word_t VALID_MASK = unpackChan('1);
endpackage

// File: rtl/ipi_chan_decode.sv
module ipi_chan_decode
  import ipi_chan_pkg::*;
(
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);
  logic       aligned;
  logic [2:0] ofs;
  logic       wrHit;
  logic       rdHit;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign ofs     = busAddr[4:2];
  assign wrHit   = busValid && busWrite && aligned;
  assign rdHit   = busValid && !busWrite && aligned;

  always_comb begin
    strb         = '0;
    strb.rdSel   = RD_ZERO;
    strb.trigWr  = wrHit && (ofs == OFS_TRIG);
    strb.statClr = wrHit && (ofs == OFS_STAT);
    strb.maskEn  = wrHit && (ofs == OFS_EN);
    strb.maskDis = wrHit && (ofs == OFS_DIS);
    if (rdHit) begin
      case (ofs)
        OFS_OBS:  strb.rdSel = RD_OBS;
        OFS_STAT: strb.rdSel = RD_STAT;
        OFS_MASK: strb.rdSel = RD_MASK;
        default:  strb.rdSel = RD_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/ipi_chan_datapath.sv
module ipi_chan_datapath
  import ipi_chan_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  word_t   busWdata,
  input  chan_t   reqIn,
  input  chan_t   obsIn,
  output word_t   busRdata,
  output chan_t   trigQ,
  output chan_t   statQ,
  output chan_t   maskQ,
  output logic    irqOut
);
  chan_t wChan;
  chan_t obsQ;
  chan_t statNext;
  chan_t maskNext;

  assign wChan = packWord(busWdata);

  always_comb begin
    statNext = statQ;
    if (strb.statClr) statNext = statNext & ~wChan;
    statNext = statNext | reqIn;
  end

  always_comb begin
    maskNext = maskQ;
    if (strb.maskEn)  maskNext = maskNext & ~wChan;
    if (strb.maskDis) maskNext = maskNext | wChan;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigQ <= '0;
      statQ <= '0;
      maskQ <= '1;
      obsQ  <= '0;
    end else begin
      trigQ <= strb.trigWr ? wChan : '0;
      statQ <= statNext;
      maskQ <= maskNext;
      obsQ  <= obsIn;
    end
  end

  assign irqOut = |(statQ & ~maskQ);

  always_comb begin
    case (strb.rdSel)
      RD_OBS:  busRdata = unpackChan(obsQ);
      RD_STAT: busRdata = unpackChan(statQ);
      RD_MASK: busRdata = unpackChan(maskQ);
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/ipi_chan_ctrl.sv
module ipi_chan_ctrl
  import ipi_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NUM_CH-1:0] reqIn,
  input  logic [NUM_CH-1:0] obsIn,
  output logic [NUM_CH-1:0] trigOut,
  output logic [NUM_CH-1:0] obsOut,
  output logic              irqOut
);
  strobe_t strb;
  chan_t   maskVec;

  ipi_chan_decode u_decode (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb)
  );

  ipi_chan_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .reqIn    (reqIn),
    .obsIn    (obsIn),
    .busRdata (busRdata),
    .trigQ    (trigOut),
    .statQ    (obsOut),
    .maskQ    (maskVec),
    .irqOut   (irqOut)
  );
endmodule

// File: rtl/ipi_chan_ctrl_chk.sv
module ipi_chan_ctrl_chk
  import ipi_chan_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [NUM_CH-1:0] reqIn,
  input logic [NUM_CH-1:0] trigOut,
  input logic [NUM_CH-1:0] obsOut,
  input logic              irqOut,
  input logic [NUM_CH-1:0] maskVec
);
  logic wrAny;
  assign wrAny = busValid && busWrite && (busAddr[1:0] == 2'b00);

  // R3
  trig_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrAny && busAddr[4:2] == OFS_TRIG) |=> (trigOut == packWord($past(busWdata))));

  // R3
  trig_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrAny && busAddr[4:2] == OFS_TRIG) |=> (trigOut == '0));

  // R4
  req_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqIn != '0) |=> ((obsOut & $past(reqIn)) == $past(reqIn)));

  // R5
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrAny && busAddr[4:2] == OFS_STAT) |=> ((obsOut & $past(obsOut)) == $past(obsOut)));

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrAny && (busAddr[4:2] == OFS_EN || busAddr[4:2] == OFS_DIS)) |=> $stable(maskVec));

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (obsOut == '0) |-> !irqOut);

  // R11
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((busRdata & ~VALID_MASK) == '0));
endmodule

bind ipi_chan_ctrl ipi_chan_ctrl_chk u_chk (.*);

// File: tb/test_ipi_chan_ctrl.sv
module test_ipi_chan_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [10:0] reqIn = '0;
  logic [10:0] obsIn = '0;
  logic [10:0] trigOut;
  logic [10:0] obsOut;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int pos [11] = '{0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27};
  localparam logic [31:0] VALID = 32'h0F0F0301;

  always #5 clk = ~clk;

  ipi_chan_ctrl i_ipi_chan_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    busValid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [31:0] b;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R12 reset state, R6 mask reset
    @(negedge clk);
    chk("R12 trig", {21'd0, trigOut}, 0);
    chk("R12 obsOut", {21'd0, obsOut}, 0);
    chk("R12 irq", {31'd0, irqOut}, 0);
    rd(5'h10, r); chk("R12 status", r, 0);
    rd(5'h14, r); chk("R6 mask reset", r, VALID);

    // R3 trigger pulse per channel plus all-ones word
    for (int i = 0; i < 11; i++) begin
      wr(5'h00, 32'h1 << pos[i]);
      chk("R3 R2 trig pulse", {21'd0, trigOut}, 32'h1 << i);
      @(negedge clk);
      chk("R3 trig end", {21'd0, trigOut}, 0);
    end
    wr(5'h00, 32'hFFFFFFFF);
    chk("R3 trig all", {21'd0, trigOut}, 32'h7FF);
    rd(5'h00, r); chk("R3 trig reads 0", r, 0);
    chk("R3 trig one cycle", {21'd0, trigOut}, 0);
    wr(5'h00, ~VALID);
    chk("R11 trig reserved", {21'd0, trigOut}, 0);

    // Per-channel request / enable / clear / disable sequence
    for (int i = 0; i < 11; i++) begin
      b = 32'h1 << pos[i];
      @(negedge clk); reqIn = 11'h1 << i;
      @(negedge clk); reqIn = '0;
      chk("R4 R10 obsOut", {21'd0, obsOut}, 32'h1 << i);
      rd(5'h10, r); chk("R4 R2 status", r, b);
      chk("R8 masked", {31'd0, irqOut}, 0);
      wr(5'h18, b);
      chk("R8 unmasked irq", {31'd0, irqOut}, 1);
      rd(5'h14, r); chk("R7 enable", r, VALID & ~b);
      rd(5'h18, r); chk("R7 enable reads 0", r, 0);
      wr(5'h10, ~b);
      rd(5'h10, r); chk("R5 write 0 keeps", r, b);
      wr(5'h10, b);
      rd(5'h10, r); chk("R5 clear", r, 0);
      chk("R8 cleared irq", {31'd0, irqOut}, 0);
      wr(5'h1C, b);
      rd(5'h14, r); chk("R7 disable", r, VALID);
      rd(5'h1C, r); chk("R7 disable reads 0", r, 0);
    end

    // R5 set wins over simultaneous clear
    @(negedge clk); reqIn = 11'h010;
    wr(5'h10, 32'h1 << pos[4]);
    reqIn = '0;
    rd(5'h10, r); chk("R5 set wins", r, 32'h1 << pos[4]);
    wr(5'h10, VALID);
    rd(5'h10, r); chk("R5 clear all", r, 0);

    // R9 observation sweep
    for (int i = 0; i < 11; i++) begin
      @(negedge clk); obsIn = 11'h1 << i;
      rd(5'h04, r); chk("R9 obs", r, 32'h1 << pos[i]);
    end
    obsIn = '0;
    wr(5'h04, 32'hFFFFFFFF);
    rd(5'h04, r); chk("R9 obs read-only", r, 0);

    // R6 mask write ignored, R11 reserved, R1 unmapped/misaligned
    wr(5'h14, 32'h0);
    rd(5'h14, r); chk("R6 mask write ignored", r, VALID);
    wr(5'h18, 32'hFFFFFFFF);
    rd(5'h14, r); chk("R11 R7 enable all", r, 0);
    wr(5'h1C, ~VALID);
    rd(5'h14, r); chk("R11 reserved disable", r, 0);
    wr(5'h19, VALID);
    rd(5'h14, r); chk("R1 misaligned ignored", r, 0);
    wr(5'h08, VALID);
    rd(5'h08, r); chk("R1 unmapped reads 0", r, 0);
    rd(5'h14, r); chk("R1 unmapped write ignored", r, 0);
    @(negedge clk); reqIn = 11'h400;
    @(negedge clk); reqIn = '0;
    chk("R8 irq unmasked ch10", {31'd0, irqOut}, 1);
    wr(5'h1C, VALID);
    chk("R8 irq after disable", {31'd0, irqOut}, 0);
    rd(5'h11, r); chk("R1 misaligned read", r, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule